// File: doc/BRIEF.md
# Multi-PHY Poll Responder

This block answers polls on the PHY side of a multi-PHY cell bus. The bus master drives a transmit and a receive port address every clock. The responder answers an address only if that address is marked in its 32-bit connected-port mask. On the edge after such a poll it drives its single cell-available line for that direction: high if the polled port has space (transmit) or a waiting cell (receive), low otherwise. For any address that is not connected it leaves the line undriven, which shows as its output enable held low. Each direction uses one active-low enable input. When that enable goes low, the responder reports which port is chosen for the transfer. The chosen port is the last connected address it saw before that edge. The cell payload is handled elsewhere.

The mask is a register with a synchronous write strobe. On reset it holds all ones, so every address is answered. A mask of all zeros is an illegal setting. While the mask is all zeros the block raises a configuration-error flag and never drives a cell-available line.

Top module: `multi_phy_poll_responder`

## Requirements
- R1: After reset the mask is all ones. Every address 0 to 31 in both directions is then answered on the edge that follows.
- R2: On each rising edge, a direction's clav output enable becomes 1 if the address sampled at that edge has its mask bit (bit index = address) set, and 0 otherwise.
- R3: When the output enable becomes 1, clav takes the status bit of the polled port sampled on the same edge: tx_space_i[addr] for transmit, rx_cell_i[addr] for receive. When the output enable is 0, clav is 0.
- R4: A mask write (cfg_wr_i high at an edge) loads cfg_wdata_i on that edge. The poll sampled on that same edge still uses the previous mask. The new mask governs from the next edge on.
- R5: While the mask register is all zeros, cfg_err_o is 1. No clav output enable or clav value is then asserted for any address. Otherwise cfg_err_o is 0.
- R6: When a direction's enable is sampled low at an edge after being sampled high at the previous edge, the selection strobe is 1 for the cycle after that edge. Its selected port is the last connected address sampled before that edge.
- R7: A poll of an address that is not connected does not change the remembered last connected address. The selected port holds its value between strobes.
- R8: The transmit and receive directions are fully independent.
- R9: Holding an enable low produces no strobe after the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Connected-port mask write strobe |
| cfg_wdata_i | input | 32 | New connected-port mask |
| tx_addr_i | input | 5 | Transmit poll address |
| tx_enb_n_i | input | 1 | Transmit enable, active low |
| tx_space_i | input | 32 | Per-port transmit space available |
| rx_addr_i | input | 5 | Receive poll address |
| rx_enb_n_i | input | 1 | Receive enable, active low |
| rx_cell_i | input | 32 | Per-port receive cell waiting |
| tx_clav_o | output | 1 | Transmit cell-available value |
| tx_clav_oe_o | output | 1 | Transmit cell-available drive enable |
| rx_clav_o | output | 1 | Receive cell-available value |
| rx_clav_oe_o | output | 1 | Receive cell-available drive enable |
| tx_sel_port_o | output | 5 | Port selected for transmit transfer |
| tx_sel_strobe_o | output | 1 | Transmit selection pulse |
| rx_sel_port_o | output | 5 | Port selected for receive transfer |
| rx_sel_strobe_o | output | 1 | Receive selection pulse |
| cfg_err_o | output | 1 | Mask is all zeros |

## Verification
Every poll result, strobe and selected port is due on the first rising edge after the inputs are applied. cfg_err_o follows the mask register, so it changes on the same edge that writes the mask. The driver sets inputs on the falling edge and pushes the expected outputs for the next rising edge into a queue. The monitor pops that entry 5 ns after the rising edge and compares it, so each check lands exactly one register stage after its stimulus.

// File: rtl/pr_pkg.sv
package pr_pkg;

    localparam int PR_PORTS  = 32;
    localparam int PR_ADDR_W = $clog2(PR_PORTS);
    localparam int PR_DIRS   = 2;

    typedef logic [PR_ADDR_W-1:0] port_idx_t;
    typedef logic [PR_PORTS-1:0]  port_vec_t;

    typedef enum logic [0:0] {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

    typedef struct packed {
        logic oe;
        logic clav;
    } poll_resp_t;

    typedef struct packed {
        logic      strobe;
        port_idx_t port;
    } sel_info_t;

    function automatic logic is_connected(port_vec_t mask, port_idx_t addr);
        return mask[addr];
    endfunction

    function automatic logic mask_legal(port_vec_t mask);
        return |mask;
    endfunction

endpackage

// File: rtl/pr_mask_reg.sv
module pr_mask_reg
    import pr_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      wr_i,
    input  port_vec_t wdata_i,
    output port_vec_t mask_o,
    output logic      err_o
);

    port_vec_t mask_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mask_q <= '1;
        end else if (wr_i) begin
            mask_q <= wdata_i;
        end
    end

    assign mask_o = mask_q;
    assign err_o  = !mask_legal(mask_q);

    // R1
    mask_rst_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (mask_q == '1));

    // R4
    mask_wr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_i |=> (mask_q == $past(wdata_i)));

endmodule

// File: rtl/pr_poll_dir.sv
module pr_poll_dir
    import pr_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  port_vec_t  mask_i,
    input  port_idx_t  addr_i,
    input  logic       enb_n_i,
    input  port_vec_t  status_i,
    output poll_resp_t resp_o,
    output sel_info_t  sel_o
);

    poll_resp_t resp_q;
    sel_info_t  sel_q;
    port_idx_t  last_q;
    logic       enb_q;
    logic       hit;
    logic       enb_fall;

    assign hit      = is_connected(mask_i, addr_i) && mask_legal(mask_i);
    assign enb_fall = enb_q && !enb_n_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            resp_q <= '0;
            sel_q  <= '0;
            last_q <= '0;
            enb_q  <= 1'b1;
        end else begin
            resp_q.oe   <= hit;
            resp_q.clav <= hit && status_i[addr_i];
            if (hit) begin
                last_q <= addr_i;
            end
            enb_q        <= enb_n_i;
            sel_q.strobe <= enb_fall;
            if (enb_fall) begin
                sel_q.port <= last_q;
            end
        end
    end

    assign resp_o = resp_q;
    assign sel_o  = sel_q;

    // R2
    quiet_unconn_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !mask_i[addr_i] |=> !resp_q.oe);

    // R3
    clav_status_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        mask_i[addr_i] |=> (resp_q.oe && (resp_q.clav == $past(status_i[addr_i]))));

    // R6
    strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        sel_q.strobe |=> !sel_q.strobe);

    // R6
    strobe_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        sel_q.strobe |-> !$past(enb_n_i));

    // R7
    port_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !sel_q.strobe |-> $stable(sel_q.port));

endmodule

// File: rtl/multi_phy_poll_responder.sv
module multi_phy_poll_responder
    import pr_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 cfg_wr_i,
    input  logic [PR_PORTS-1:0]  cfg_wdata_i,
    input  logic [PR_ADDR_W-1:0] tx_addr_i,
    input  logic                 tx_enb_n_i,
    input  logic [PR_PORTS-1:0]  tx_space_i,
    input  logic [PR_ADDR_W-1:0] rx_addr_i,
    input  logic                 rx_enb_n_i,
    input  logic [PR_PORTS-1:0]  rx_cell_i,
    output logic                 tx_clav_o,
    output logic                 tx_clav_oe_o,
    output logic                 rx_clav_o,
    output logic                 rx_clav_oe_o,
    output logic [PR_ADDR_W-1:0] tx_sel_port_o,
    output logic                 tx_sel_strobe_o,
    output logic [PR_ADDR_W-1:0] rx_sel_port_o,
    output logic                 rx_sel_strobe_o,
    output logic                 cfg_err_o
);

    port_vec_t                 mask;
    port_idx_t  [PR_DIRS-1:0]  addr;
    logic       [PR_DIRS-1:0]  enb_n;
    port_vec_t  [PR_DIRS-1:0]  status;
    poll_resp_t [PR_DIRS-1:0]  resp;
    sel_info_t  [PR_DIRS-1:0]  sel;

    assign addr[DIR_TX]   = tx_addr_i;
    assign addr[DIR_RX]   = rx_addr_i;
    assign enb_n[DIR_TX]  = tx_enb_n_i;
    assign enb_n[DIR_RX]  = rx_enb_n_i;
    assign status[DIR_TX] = tx_space_i;
    assign status[DIR_RX] = rx_cell_i;

    pr_mask_reg mask_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_i    (cfg_wr_i),
        .wdata_i (cfg_wdata_i),
        .mask_o  (mask),
        .err_o   (cfg_err_o)
    );

    for (genvar d = 0; d < PR_DIRS; d++) begin : g_dir
        pr_poll_dir dir_i (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .mask_i   (mask),
            .addr_i   (addr[d]),
            .enb_n_i  (enb_n[d]),
            .status_i (status[d]),
            .resp_o   (resp[d]),
            .sel_o    (sel[d])
        );
    end

    assign tx_clav_o       = resp[DIR_TX].clav;
    assign tx_clav_oe_o    = resp[DIR_TX].oe;
    assign rx_clav_o       = resp[DIR_RX].clav;
    assign rx_clav_oe_o    = resp[DIR_RX].oe;
    assign tx_sel_port_o   = sel[DIR_TX].port;
    assign tx_sel_strobe_o = sel[DIR_TX].strobe;
    assign rx_sel_port_o   = sel[DIR_RX].port;
    assign rx_sel_strobe_o = sel[DIR_RX].strobe;

    // R5
    err_silent_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cfg_err_o |=> (!tx_clav_oe_o && !rx_clav_oe_o && !tx_clav_o && !rx_clav_o));

endmodule

// File: tb/multi_phy_poll_responder_tb_top.sv
module multi_phy_poll_responder_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [31:0] cfg_wdata;
    logic [4:0]  tx_addr, rx_addr;
    logic        tx_enb_n, rx_enb_n;
    logic [31:0] tx_space, rx_cell;
    logic        tx_clav, tx_clav_oe, rx_clav, rx_clav_oe;
    logic [4:0]  tx_sel_port, rx_sel_port;
    logic        tx_sel_strobe, rx_sel_strobe, cfg_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    multi_phy_poll_responder dut_i (
        .clk_i(clk), .rst_i(rst), .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata),
        .tx_addr_i(tx_addr), .tx_enb_n_i(tx_enb_n), .tx_space_i(tx_space),
        .rx_addr_i(rx_addr), .rx_enb_n_i(rx_enb_n), .rx_cell_i(rx_cell),
        .tx_clav_o(tx_clav), .tx_clav_oe_o(tx_clav_oe),
        .rx_clav_o(rx_clav), .rx_clav_oe_o(rx_clav_oe),
        .tx_sel_port_o(tx_sel_port), .tx_sel_strobe_o(tx_sel_strobe),
        .rx_sel_port_o(rx_sel_port), .rx_sel_strobe_o(rx_sel_strobe),
        .cfg_err_o(cfg_err)
    );

    typedef struct {
        logic [1:0] oe;
        logic [1:0] clav;
        logic [1:0] strobe;
        logic [4:0] port_tx;
        logic [4:0] port_rx;
        logic       err;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    // independent reference state
    logic [31:0] m_mask;
    logic [4:0]  m_last [2];
    logic        m_enb_prev [2];
    logic [4:0]  m_port [2];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mask = '1;
        for (int d = 0; d < 2; d++) begin
            m_last[d] = '0;
            m_enb_prev[d] = 1'b1;
            m_port[d] = '0;
        end
    endtask

    // drive one cycle on the falling edge and queue the expected result
    task automatic cycle(string tag, logic [4:0] ta, logic te, logic [4:0] ra, logic re,
                         logic wr = 1'b0, logic [31:0] wd = '0);
        exp_t e;
        logic [4:0] a [2];
        logic en [2];
        logic [31:0] st [2];
        @(negedge clk);
        tx_addr = ta; tx_enb_n = te; rx_addr = ra; rx_enb_n = re;
        cfg_wr = wr; cfg_wdata = wd;
        a[0] = ta; a[1] = ra; en[0] = te; en[1] = re;
        st[0] = tx_space; st[1] = rx_cell;
        for (int d = 0; d < 2; d++) begin
            e.oe[d]     = m_mask[a[d]];
            e.clav[d]   = m_mask[a[d]] & st[d][a[d]];
            e.strobe[d] = m_enb_prev[d] & !en[d];
            if (e.strobe[d]) m_port[d] = m_last[d];
            if (m_mask[a[d]]) m_last[d] = a[d];
            m_enb_prev[d] = en[d];
        end
        if (wr) m_mask = wd;
        e.port_tx = m_port[0];
        e.port_rx = m_port[1];
        e.err = (m_mask == 32'h0);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compare 5 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk({e.tag, " R2 tx oe"}, 32'(tx_clav_oe), 32'(e.oe[0]));
                chk({e.tag, " R3 tx clav"}, 32'(tx_clav), 32'(e.clav[0]));
                chk({e.tag, " R8 rx oe"}, 32'(rx_clav_oe), 32'(e.oe[1]));
                chk({e.tag, " R3 rx clav"}, 32'(rx_clav), 32'(e.clav[1]));
                chk({e.tag, " R6 tx strobe"}, 32'(tx_sel_strobe), 32'(e.strobe[0]));
                chk({e.tag, " R6 rx strobe"}, 32'(rx_sel_strobe), 32'(e.strobe[1]));
                chk({e.tag, " R7 tx port"}, 32'(tx_sel_port), 32'(e.port_tx));
                chk({e.tag, " R7 rx port"}, 32'(rx_sel_port), 32'(e.port_rx));
                chk({e.tag, " R5 err"}, 32'(cfg_err), 32'(e.err));
            end
        end
    end

    initial begin
        int wd_cnt = 0;
        while (!done && wd_cnt < 20000) begin
            @(posedge clk);
            wd_cnt++;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_wdata = '0;
        tx_addr = '0; rx_addr = '0; tx_enb_n = 1'b1; rx_enb_n = 1'b1;
        tx_space = 32'hA5C3_0F96; rx_cell = 32'h5A3C_F069;
        model_reset();
        repeat (3) @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state (R1)
        chk("R1 reset oe", 32'({tx_clav_oe, rx_clav_oe}), 32'h0);
        chk("R1 reset strobe", 32'({tx_sel_strobe, rx_sel_strobe}), 32'h0);
        chk("R1 reset port", 32'({tx_sel_port, rx_sel_port}), 32'h0);
        chk("R1 reset err", 32'(cfg_err), 32'h0);

        // R1 R2 R3: every address answered after reset
        for (int i = 0; i < 32; i++) cycle("R1 sweep", 5'(i), 1'b1, 5'(31 - i), 1'b1);
        tx_space = 32'hFFFF_0000; rx_cell = 32'h0000_FFFF;
        for (int i = 0; i < 32; i++) cycle("R3 sweep", 5'(i), 1'b1, 5'(i), 1'b1);

        // R4: write mask; same-edge poll uses old mask
        cycle("R4 wr", 5'd3, 1'b1, 5'd3, 1'b1, 1'b1, 32'h0000_00F0);
        cycle("R4 new", 5'd3, 1'b1, 5'd3, 1'b1);
        cycle("R4 new", 5'd5, 1'b1, 5'd9, 1'b1);
        cycle("R2 mix", 5'd7, 1'b1, 5'd4, 1'b1);

        // R6 R7: select last connected address, unconnected ignored
        cycle("R7 poll", 5'd5, 1'b1, 5'd6, 1'b1);
        cycle("R7 unconn", 5'd2, 1'b1, 5'd31, 1'b1);
        cycle("R6 fall tx", 5'd20, 1'b0, 5'd4, 1'b1);
        // R9: held low, no new strobe; R8 rx falls alone
        cycle("R9 hold", 5'd4, 1'b0, 5'd1, 1'b0);
        cycle("R9 hold", 5'd6, 1'b0, 5'd7, 1'b0);
        cycle("R9 hold", 5'd6, 1'b1, 5'd7, 1'b1);
        cycle("R6 fall both", 5'd0, 1'b0, 5'd0, 1'b0);
        cycle("R7 idle", 5'd0, 1'b1, 5'd0, 1'b1);

        // R5: all-zero mask
        cycle("R5 wr zero", 5'd4, 1'b1, 5'd5, 1'b1, 1'b1, 32'h0);
        for (int i = 0; i < 32; i++) cycle("R5 silent", 5'(i), 1'b1, 5'(i), 1'b1);
        cycle("R5 restore", 5'd1, 1'b1, 5'd1, 1'b1, 1'b1, 32'h8000_0001);
        cycle("R5 after", 5'd31, 1'b1, 5'd0, 1'b1);
        cycle("R5 after", 5'd30, 1'b1, 5'd31, 1'b1);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule